// File: doc/BRIEF.md
# Nibble-Multiplexed Chroma Formatter Pair

This block sits at the two edges of a vertical video processor and converts chroma between full 8-bit samples and narrow 2-bit lanes. Each of U and V is carried on its own 2-bit lane. One 8-bit chroma sample is spread over four consecutive luma pixels, most significant pair first, which gives 4:1:1 subsampling. Luma is straight binary, with black at 16 and white at 191. Chroma is two's complement, swinging about ±90 around zero.

The output half (the reformatter) takes full Y, U and V at pixel rate. It passes Y through and serialises U and V into the lanes. Outside the active window it drives the blanking codes, 16 on luma and 0 on chroma. The input half (the deformatter) takes a double-rate stream in which words from two fields alternate, first A and then B. It splits this stream into two field streams and rebuilds each 8-bit U and V sample from its four slices. Both halves keep a four-step group phase that restarts on every horizontal reference, so group alignment is re-established on each line. An active line is 840 pixels, or 210 chroma groups.

Top module: `chroma_nibble_fmt`

## Requirements
- R1: While reset is held, `fmt_y_o` is 16, both formatter lanes are 0, and all three deformatter strobes are 0.
- R2: An active formatter pixel appears unchanged on `fmt_y_o` one clock later.
- R3: An inactive formatter cycle yields `fmt_y_o` = 16 and both lanes = 0 one clock later, whatever the inputs are.
- R4: The formatter group phase k is 0 on the pixel that carries `fmt_href` and then counts 0,1,2,3,0 over active pixels. Pixel k of a group emits bits [7-2k:6-2k] of the group's U and V on the lanes one clock later, so phase 0 carries bits 7:6 and phase 3 carries bits 1:0.
- R5: U and V are sampled only at phase 0. Values presented at phases 1 to 3 have no effect on the lanes.
- R6: `fmt_href` in the middle of a group restarts the phase at 0 and latches a new sample on that pixel.
- R7: After `dfm_href`, active deformatter words alternate field A (the word carrying href) then field B. One clock after each B word, `dfm_y_vld` pulses with that pixel pair on `dfm_y_a` and `dfm_y_b`.
- R8: For each field, the four lane slices of a group are joined MSB first, {s0,s1,s2,s3}, and presented on `dfm_u_*` and `dfm_v_*`. This happens one clock after that field's fourth slice, with a one-cycle `dfm_c_vld_*` pulse.
- R9: A deformatter cycle with `dfm_active` low produces no strobe, leaves `dfm_y_a` and `dfm_y_b` unchanged, and does not advance the field or group position.
- R10: Two lines passed through the formatter and then interleaved into the deformatter return every Y bit-exact, and return each group's phase-0 U and V bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_href | input | 1 | Line start for the formatter; marks group phase 0 |
| fmt_active | input | 1 | Formatter active-video qualifier |
| fmt_y | input | 8 | Formatter luma in |
| fmt_u | input | 8 | Formatter U in (two's complement) |
| fmt_v | input | 8 | Formatter V in (two's complement) |
| fmt_y_o | output | 8 | Formatter luma out, blank code 16 |
| fmt_u_lane | output | 2 | U slice lane |
| fmt_v_lane | output | 2 | V slice lane |
| dfm_href | input | 1 | Line start for the deformatter; first word is field A |
| dfm_active | input | 1 | Deformatter word qualifier |
| dfm_y | input | 8 | Interleaved luma word |
| dfm_u_lane | input | 2 | Interleaved U slice |
| dfm_v_lane | input | 2 | Interleaved V slice |
| dfm_y_a | output | 8 | Field A luma |
| dfm_y_b | output | 8 | Field B luma |
| dfm_y_vld | output | 1 | Luma pair valid |
| dfm_u_a | output | 8 | Field A rebuilt U |
| dfm_v_a | output | 8 | Field A rebuilt V |
| dfm_c_vld_a | output | 1 | Field A chroma valid |
| dfm_u_b | output | 8 | Field B rebuilt U |
| dfm_v_b | output | 8 | Field B rebuilt V |
| dfm_c_vld_b | output | 1 | Field B chroma valid |

## Verification
A slipped formatter group phase shows at once as the wrong bit pair on the lanes on the next pixel. In the round trip it also shows as a rotated U/V value at the next group boundary, at most four pixels later. A field toggle that is out of step in the deformatter swaps luma between `dfm_y_a` and `dfm_y_b`, and moves the chroma strobe to the wrong field, within one pixel pair. A phase that advances on gap words corrupts every sample after the gap. Each of these faults therefore reaches the ports within one chroma group.

// File: rtl/cnf_pkg.sv
package cnf_pkg;
  localparam int unsigned DEF_PIX_W  = 8;
  localparam int unsigned DEF_LANE_W = 2;
  localparam int unsigned NUM_FIELDS = 2;
  // Field order on the interleaved input: first word after href is A.
  localparam logic FLD_A = 1'b0;
  localparam logic FLD_B = 1'b1;
endpackage

// File: rtl/cnf_phase.sv
module cnf_phase #(
  parameter  int unsigned SLICES = 4,
  localparam int unsigned PH_W   = $clog2(SLICES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            href,
  input  logic            adv,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  logic [PH_W-1:0] cnt;

  always_comb begin
    phase = href ? '0 : cnt;
    last  = (phase == PH_W'(SLICES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (adv)  cnt <= last ? '0 : phase + 1'b1;
    else if (href) cnt <= '0;
  end
endmodule

// File: rtl/cnf_reformatter.sv
module cnf_reformatter #(
  parameter  int unsigned PIX_W   = 8,
  parameter  int unsigned LANE_W  = 2,
  parameter  logic [PIX_W-1:0] BLANK_Y = 8'd16,
  parameter  logic [PIX_W-1:0] BLANK_C = '0,
  localparam int unsigned SLICES  = PIX_W / LANE_W,
  localparam int unsigned PH_W    = $clog2(SLICES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              href,
  input  logic              active,
  input  logic [PIX_W-1:0]  y_in,
  input  logic [PIX_W-1:0]  u_in,
  input  logic [PIX_W-1:0]  v_in,
  output logic [PIX_W-1:0]  y_out,
  output logic [LANE_W-1:0] u_lane,
  output logic [LANE_W-1:0] v_lane,
  output logic [PH_W-1:0]   phase,
  output logic              grp_load
);
  // Slice k of a sample, counted from the most significant end.
  function automatic logic [LANE_W-1:0] slice_of(input logic [PIX_W-1:0] s,
                                                 input logic [PH_W-1:0]  k);
    int unsigned sh;
    sh = LANE_W * (SLICES - 1 - int'(k));
    return LANE_W'(s >> sh);
  endfunction

  logic              unused_last;
  logic [PIX_W-1:0]  u_hold, v_hold;
  logic [PIX_W-1:0]  u_src, v_src;

  cnf_phase #(.SLICES(SLICES)) u_phase (
    .clk(clk), .rst_n(rst_n), .href(href), .adv(active),
    .phase(phase), .last(unused_last)
  );

  always_comb begin
    grp_load = active && (phase == '0);
    u_src    = grp_load ? u_in : u_hold;
    v_src    = grp_load ? v_in : v_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_hold <= BLANK_C;
      v_hold <= BLANK_C;
    end else if (grp_load) begin
      u_hold <= u_in;
      v_hold <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_out  <= BLANK_Y;
      u_lane <= slice_of(BLANK_C, '0);
      v_lane <= slice_of(BLANK_C, '0);
    end else if (active) begin
      y_out  <= y_in;
      u_lane <= slice_of(u_src, phase);
      v_lane <= slice_of(v_src, phase);
    end else begin
      y_out  <= BLANK_Y;
      u_lane <= slice_of(BLANK_C, phase);
      v_lane <= slice_of(BLANK_C, phase);
    end
  end
endmodule

// File: rtl/cnf_field_lane.sv
module cnf_field_lane #(
  parameter  int unsigned PIX_W  = 8,
  parameter  int unsigned LANE_W = 2,
  localparam int unsigned ACC_W  = PIX_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              last,
  input  logic [PIX_W-1:0]  y_in,
  input  logic [LANE_W-1:0] u_sl,
  input  logic [LANE_W-1:0] v_sl,
  output logic [PIX_W-1:0]  y_q,
  output logic [PIX_W-1:0]  u_q,
  output logic [PIX_W-1:0]  v_q,
  output logic              c_vld
);
  // Earlier slices occupy the high bits: first slice received is the MSB pair.
  function automatic logic [PIX_W-1:0] join_sample(input logic [ACC_W-1:0]  acc,
                                                   input logic [LANE_W-1:0] sl);
    return {acc, sl};
  endfunction

  function automatic logic [ACC_W-1:0] push_slice(input logic [ACC_W-1:0]  acc,
                                                  input logic [LANE_W-1:0] sl);
    return ACC_W'({acc, sl});
  endfunction

  logic [ACC_W-1:0] u_acc, v_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q   <= '0;
      u_q   <= '0;
      v_q   <= '0;
      u_acc <= '0;
      v_acc <= '0;
      c_vld <= 1'b0;
    end else begin
      c_vld <= en && last;
      if (en) begin
        y_q   <= y_in;
        u_acc <= push_slice(u_acc, u_sl);
        v_acc <= push_slice(v_acc, v_sl);
        if (last) begin
          u_q <= join_sample(u_acc, u_sl);
          v_q <= join_sample(v_acc, v_sl);
        end
      end
    end
  end
endmodule

// File: rtl/cnf_deformatter.sv
module cnf_deformatter #(
  parameter  int unsigned PIX_W  = 8,
  parameter  int unsigned LANE_W = 2,
  localparam int unsigned SLICES = PIX_W / LANE_W,
  localparam int unsigned PH_W   = $clog2(SLICES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              href,
  input  logic              active,
  input  logic [PIX_W-1:0]  y_in,
  input  logic [LANE_W-1:0] u_sl,
  input  logic [LANE_W-1:0] v_sl,
  output logic [PIX_W-1:0]  y_a,
  output logic [PIX_W-1:0]  y_b,
  output logic              y_vld,
  output logic [PIX_W-1:0]  u_a,
  output logic [PIX_W-1:0]  v_a,
  output logic              c_vld_a,
  output logic [PIX_W-1:0]  u_b,
  output logic [PIX_W-1:0]  v_b,
  output logic              c_vld_b,
  output logic [PH_W-1:0]   phase,
  output logic              fsel
);
  import cnf_pkg::*;

  logic tog;
  logic last;
  logic pair_done;

  logic [PIX_W-1:0] ln_y [NUM_FIELDS];
  logic [PIX_W-1:0] ln_u [NUM_FIELDS];
  logic [PIX_W-1:0] ln_v [NUM_FIELDS];
  logic             ln_vld [NUM_FIELDS];

  always_comb begin
    fsel      = href ? FLD_A : tog;
    pair_done = active && (fsel == FLD_B);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tog <= FLD_A;
    else if (active) tog <= (fsel == FLD_A) ? FLD_B : FLD_A;
    else if (href)   tog <= FLD_A;
  end

  // The group phase is shared by both fields and moves on after each B word.
  cnf_phase #(.SLICES(SLICES)) u_phase (
    .clk(clk), .rst_n(rst_n), .href(href), .adv(pair_done),
    .phase(phase), .last(last)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_lane
    logic en_f;
    assign en_f = active && (fsel == 1'(f));
    cnf_field_lane #(.PIX_W(PIX_W), .LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en_f), .last(last),
      .y_in(y_in), .u_sl(u_sl), .v_sl(v_sl),
      .y_q(ln_y[f]), .u_q(ln_u[f]), .v_q(ln_v[f]), .c_vld(ln_vld[f])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) y_vld <= 1'b0;
    else        y_vld <= pair_done;
  end

  always_comb begin
    y_a     = ln_y[0];
    y_b     = ln_y[1];
    u_a     = ln_u[0];
    v_a     = ln_v[0];
    c_vld_a = ln_vld[0];
    u_b     = ln_u[1];
    v_b     = ln_v[1];
    c_vld_b = ln_vld[1];
  end
endmodule

// File: rtl/chroma_nibble_fmt.sv
module chroma_nibble_fmt #(
  parameter  int unsigned PIX_W   = cnf_pkg::DEF_PIX_W,
  parameter  int unsigned LANE_W  = cnf_pkg::DEF_LANE_W,
  parameter  logic [PIX_W-1:0] BLANK_Y = 8'd16,
  parameter  logic [PIX_W-1:0] BLANK_C = '0,
  localparam int unsigned SLICES  = PIX_W / LANE_W,
  localparam int unsigned PH_W    = $clog2(SLICES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_href,
  input  logic              fmt_active,
  input  logic [PIX_W-1:0]  fmt_y,
  input  logic [PIX_W-1:0]  fmt_u,
  input  logic [PIX_W-1:0]  fmt_v,
  output logic [PIX_W-1:0]  fmt_y_o,
  output logic [LANE_W-1:0] fmt_u_lane,
  output logic [LANE_W-1:0] fmt_v_lane,
  input  logic              dfm_href,
  input  logic              dfm_active,
  input  logic [PIX_W-1:0]  dfm_y,
  input  logic [LANE_W-1:0] dfm_u_lane,
  input  logic [LANE_W-1:0] dfm_v_lane,
  output logic [PIX_W-1:0]  dfm_y_a,
  output logic [PIX_W-1:0]  dfm_y_b,
  output logic              dfm_y_vld,
  output logic [PIX_W-1:0]  dfm_u_a,
  output logic [PIX_W-1:0]  dfm_v_a,
  output logic              dfm_c_vld_a,
  output logic [PIX_W-1:0]  dfm_u_b,
  output logic [PIX_W-1:0]  dfm_v_b,
  output logic              dfm_c_vld_b
);
  // Internal events brought out for the bound checker.
  logic [PH_W-1:0] fmt_phase;
  logic            fmt_load;
  logic [PH_W-1:0] dfm_phase;
  logic            dfm_fsel;

  cnf_reformatter #(
    .PIX_W(PIX_W), .LANE_W(LANE_W), .BLANK_Y(BLANK_Y), .BLANK_C(BLANK_C)
  ) u_fmt (
    .clk(clk), .rst_n(rst_n), .href(fmt_href), .active(fmt_active),
    .y_in(fmt_y), .u_in(fmt_u), .v_in(fmt_v),
    .y_out(fmt_y_o), .u_lane(fmt_u_lane), .v_lane(fmt_v_lane),
    .phase(fmt_phase), .grp_load(fmt_load)
  );

  cnf_deformatter #(.PIX_W(PIX_W), .LANE_W(LANE_W)) u_dfm (
    .clk(clk), .rst_n(rst_n), .href(dfm_href), .active(dfm_active),
    .y_in(dfm_y), .u_sl(dfm_u_lane), .v_sl(dfm_v_lane),
    .y_a(dfm_y_a), .y_b(dfm_y_b), .y_vld(dfm_y_vld),
    .u_a(dfm_u_a), .v_a(dfm_v_a), .c_vld_a(dfm_c_vld_a),
    .u_b(dfm_u_b), .v_b(dfm_v_b), .c_vld_b(dfm_c_vld_b),
    .phase(dfm_phase), .fsel(dfm_fsel)
  );
endmodule

// File: rtl/cnf_checker.sv
module cnf_checker #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LANE_W = 2,
  parameter int unsigned PH_W   = 2,
  parameter logic [PIX_W-1:0] BLANK_Y = 8'd16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fmt_href,
  input logic              fmt_active,
  input logic [PIX_W-1:0]  fmt_y,
  input logic [PIX_W-1:0]  fmt_u,
  input logic [PIX_W-1:0]  fmt_v,
  input logic [PIX_W-1:0]  fmt_y_o,
  input logic [LANE_W-1:0] fmt_u_lane,
  input logic [LANE_W-1:0] fmt_v_lane,
  input logic [PH_W-1:0]   fmt_phase,
  input logic              dfm_active,
  input logic              dfm_fsel,
  input logic              dfm_y_vld,
  input logic              dfm_c_vld_a,
  input logic              dfm_c_vld_b
);
  // R2
  a_r2_luma_pass: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_active |=> (fmt_y_o == $past(fmt_y)));

  // R3
  a_r3_blank_codes: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_active |=> (fmt_y_o == BLANK_Y && fmt_u_lane == '0 && fmt_v_lane == '0));

  // R4: phase steps by one per active pixel unless a line start intervenes
  a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fmt_active) && !fmt_href)
      |-> (fmt_phase == PH_W'($past(fmt_phase) + 1'b1)));

  // R5: the phase-0 pixel's MSB pair goes out next
  a_r5_group_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_active && fmt_phase == '0) |=>
      (fmt_u_lane == $past(fmt_u[PIX_W-1 -: LANE_W]) &&
       fmt_v_lane == $past(fmt_v[PIX_W-1 -: LANE_W])));

  // R7
  a_r7_pair_after_b: assert property (@(posedge clk) disable iff (!rst_n)
    dfm_y_vld |-> $past(dfm_active && dfm_fsel));

  // R8: both fields never complete a sample on the same word
  a_r8_field_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dfm_c_vld_a && dfm_c_vld_b));

  // R9
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dfm_active |=> (!dfm_y_vld && !dfm_c_vld_a && !dfm_c_vld_b));
endmodule

bind chroma_nibble_fmt cnf_checker #(
  .PIX_W(PIX_W), .LANE_W(LANE_W), .PH_W(PH_W), .BLANK_Y(BLANK_Y)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fmt_href(fmt_href), .fmt_active(fmt_active),
  .fmt_y(fmt_y), .fmt_u(fmt_u), .fmt_v(fmt_v),
  .fmt_y_o(fmt_y_o), .fmt_u_lane(fmt_u_lane), .fmt_v_lane(fmt_v_lane),
  .fmt_phase(fmt_phase),
  .dfm_active(dfm_active), .dfm_fsel(dfm_fsel),
  .dfm_y_vld(dfm_y_vld), .dfm_c_vld_a(dfm_c_vld_a), .dfm_c_vld_b(dfm_c_vld_b)
);

// File: tb/chroma_nibble_fmt_tb.sv
module chroma_nibble_fmt_tb;
  localparam int LINE = 840;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_href = 0, fmt_active = 0;
  logic [7:0] fmt_y = 0, fmt_u = 0, fmt_v = 0;
  logic [7:0] fmt_y_o;
  logic [1:0] fmt_u_lane, fmt_v_lane;
  logic dfm_href = 0, dfm_active = 0;
  logic [7:0] dfm_y = 0;
  logic [1:0] dfm_u_lane = 0, dfm_v_lane = 0;
  logic [7:0] dfm_y_a, dfm_y_b, dfm_u_a, dfm_v_a, dfm_u_b, dfm_v_b;
  logic dfm_y_vld, dfm_c_vld_a, dfm_c_vld_b;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] ly [2][LINE];
  logic [7:0] lu [2][LINE];
  logic [7:0] lv [2][LINE];
  logic [7:0] cy [2][LINE];
  logic [1:0] cu [2][LINE];
  logic [1:0] cv [2][LINE];

  always #2 clk = ~clk;

  chroma_nibble_fmt u_dut (
    .clk(clk), .rst_n(rst_n),
    .fmt_href(fmt_href), .fmt_active(fmt_active),
    .fmt_y(fmt_y), .fmt_u(fmt_u), .fmt_v(fmt_v),
    .fmt_y_o(fmt_y_o), .fmt_u_lane(fmt_u_lane), .fmt_v_lane(fmt_v_lane),
    .dfm_href(dfm_href), .dfm_active(dfm_active),
    .dfm_y(dfm_y), .dfm_u_lane(dfm_u_lane), .dfm_v_lane(dfm_v_lane),
    .dfm_y_a(dfm_y_a), .dfm_y_b(dfm_y_b), .dfm_y_vld(dfm_y_vld),
    .dfm_u_a(dfm_u_a), .dfm_v_a(dfm_v_a), .dfm_c_vld_a(dfm_c_vld_a),
    .dfm_u_b(dfm_u_b), .dfm_v_b(dfm_v_b), .dfm_c_vld_b(dfm_c_vld_b)
  );

  // Bench restatement: pair k counted from the top, as integer arithmetic.
  function automatic logic [1:0] pair_k(input logic [7:0] s, input int k);
    return 2'((int'(s) / (1 << (6 - 2 * k))) % 4);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_fmt(input int f);
    for (int i = 0; i < LINE; i++) begin
      fmt_href = (i == 0); fmt_active = 1'b1;
      fmt_y = ly[f][i]; fmt_u = lu[f][i]; fmt_v = lv[f][i];
      @(negedge clk);
      begin
        int k = i % 4;
        int g = i - k;
        string rq = (k == 0) ? "R4" : "R5";
        chk("R2", "luma", int'(fmt_y_o), int'(ly[f][i]));
        chk(rq, "u lane", int'(fmt_u_lane), int'(pair_k(lu[f][g], k)));
        chk(rq, "v lane", int'(fmt_v_lane), int'(pair_k(lv[f][g], k)));
      end
      cy[f][i] = fmt_y_o; cu[f][i] = fmt_u_lane; cv[f][i] = fmt_v_lane;
    end
    fmt_href = 1'b0; fmt_active = 1'b0;
  endtask

  task automatic run_blank(input int n);
    for (int i = 0; i < n; i++) begin
      fmt_href = 1'b0; fmt_active = 1'b0;
      fmt_y = 8'($urandom); fmt_u = 8'($urandom); fmt_v = 8'($urandom);
      @(negedge clk);
      chk("R3", "blank y", int'(fmt_y_o), 16);
      chk("R3", "blank u", int'(fmt_u_lane), 0);
      chk("R3", "blank v", int'(fmt_v_lane), 0);
    end
  endtask

  task automatic fmt_pix(input bit h, input logic [7:0] u, input int exp_lane);
    fmt_href = h; fmt_active = 1'b1; fmt_y = 8'd100; fmt_u = u; fmt_v = u;
    @(negedge clk);
    chk("R6", "restart lane", int'(fmt_u_lane), exp_lane);
  endtask

  task automatic run_dfm(input int npix, input int gap, input string tag);
    logic [7:0] pa, pb;
    int w;
    pa = dfm_y_a; pb = dfm_y_b; w = 0;
    for (int i = 0; i < npix; i++) begin
      for (int f = 0; f < 2; f++) begin
        if (gap != 0 && w != 0 && (w % gap) == 0) begin
          dfm_href = 1'b0; dfm_active = 1'b0;
          dfm_y = 8'($urandom); dfm_u_lane = 2'($urandom); dfm_v_lane = 2'($urandom);
          @(negedge clk);
          chk("R9", "gap strobes", int'({dfm_y_vld, dfm_c_vld_a, dfm_c_vld_b}), 0);
          chk("R9", "gap y hold", int'({dfm_y_a, dfm_y_b}), int'({pa, pb}));
        end
        w++;
        dfm_href = (i == 0 && f == 0); dfm_active = 1'b1;
        dfm_y = cy[f][i]; dfm_u_lane = cu[f][i]; dfm_v_lane = cv[f][i];
        @(negedge clk);
        begin
          bit done = (i % 4) == 3;
          if (f == 0) begin
            chk("R7", "no pair after A", int'(dfm_y_vld), 0);
            chk(tag, "vld a", int'({dfm_c_vld_a, dfm_c_vld_b}), done ? 2 : 0);
            if (done) begin
              chk(tag, "u a", int'(dfm_u_a), int'(lu[0][i-3]));
              chk(tag, "v a", int'(dfm_v_a), int'(lv[0][i-3]));
            end
          end else begin
            chk("R7", "pair vld", int'(dfm_y_vld), 1);
            chk(tag, "y a", int'(dfm_y_a), int'(ly[0][i]));
            chk(tag, "y b", int'(dfm_y_b), int'(ly[1][i]));
            chk(tag, "vld b", int'({dfm_c_vld_a, dfm_c_vld_b}), done ? 1 : 0);
            if (done) begin
              chk(tag, "u b", int'(dfm_u_b), int'(lu[1][i-3]));
              chk(tag, "v b", int'(dfm_v_b), int'(lv[1][i-3]));
            end
          end
        end
        pa = dfm_y_a; pb = dfm_y_b;
      end
    end
    dfm_href = 1'b0; dfm_active = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset y", int'(fmt_y_o), 16);
    chk("R1", "reset lanes", int'({fmt_u_lane, fmt_v_lane}), 0);
    chk("R1", "reset strobes", int'({dfm_y_vld, dfm_c_vld_a, dfm_c_vld_b}), 0);
    rst_n = 1'b1;

    // R6: href at pixel 2 restarts the group with a fresh latch
    fmt_pix(1'b1, 8'hC0, 3);
    fmt_pix(1'b0, 8'h00, 0);
    fmt_pix(1'b1, 8'h70, 1);
    fmt_pix(1'b0, 8'h00, 3);
    run_blank(4);

    // R8: direct slices of known samples
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < 4; i++) begin
        ly[f][i] = 8'($urandom);
        lu[f][i] = (f == 0) ? 8'hB4 : 8'h69;
        lv[f][i] = (f == 0) ? 8'h2D : 8'hF0;
        cy[f][i] = ly[f][i];
        cu[f][i] = pair_k(lu[f][0], i);
        cv[f][i] = pair_k(lv[f][0], i);
      end
    end
    run_dfm(4, 0, "R8");

    // R10: random lines, round trip with gap words every 7 slots
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < LINE; i++) begin
        ly[f][i] = 8'($urandom); lu[f][i] = 8'($urandom); lv[f][i] = 8'($urandom);
      end
    run_fmt(0);
    run_blank(3);
    run_fmt(1);
    run_blank(5);
    run_dfm(LINE, 7, "R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule